// File: doc/BRIEF.md
# Graphics-mode command decoder

This block sits behind the command pins of a two-bank synchronous graphics DRAM. Every clock it samples chip select, the three row/column/write strobes, a special-function select pin, the bank bit and the address bus, classifies the command, and drives a registered one-hot operation code for the rest of the device. When the special-function pin is high, three commands take on their graphics meaning. Activate turns on per-bit write masking. Write becomes a block write. The mode-set command becomes a special mode-set, which loads the color and/or mask register from the data bus over one or two following data cycles.

The decoder also screens commands against the state of the banks, which it tracks itself. Mode-set, special mode-set and auto refresh are refused while any bank is open. Activate is refused on a bank that is already open. Read and write are refused on a bank that is idle. While a register load is in progress, every command other than NOP or deselect is refused and has no effect. A refused command shows up as a dedicated "rejected" operation code. The memory array and the block-write datapath are outside this block.

The control is a four-state load sequencer. The states are `ST_READY` (accepting commands), `ST_MASK_FIRST` (mask data cycle, color to follow), `ST_MASK_ONLY` (single mask data cycle) and `ST_COLOR_LAST` (color data cycle). Its transitions are:
- READY to MASK_FIRST when an accepted special mode-set has both select bits set.
- READY to MASK_ONLY when it has only the mask select bit set.
- READY to COLOR_LAST when it has only the color select bit set.
- MASK_FIRST to COLOR_LAST unconditionally.
- MASK_ONLY to READY and COLOR_LAST to READY unconditionally.
- READY stays in READY otherwise.

Top module: `gfx_cmd_decoder`

## Requirements
- R1: After reset, `op` is 12'h001 (NOP), and `color_reg` and `mask_reg` are zero.
- R2: With `cmd_sel` low, the command sampled at a rising edge appears on `op` after that edge. The strobe codes are given as {cs_n,ras_n,cas_n,we_n}. cs_n high means deselect, which is NOP, as is 0111. 0011 is activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 auto refresh and 0000 mode set. The `op` bit positions are: 0 NOP, 1 activate, 2 activate with write-per-bit, 3 read, 4 write, 5 block write, 6 burst stop, 7 precharge, 8 auto refresh, 9 mode set, 10 special mode set, 11 rejected.
- R3: With `cmd_sel` high, activate decodes as activate with write-per-bit (bit 2) and write decodes as block write (bit 5). All other commands decode as they do with `cmd_sel` low.
- R4: Code 0000 with `cmd_sel` high decodes as special mode set (bit 10).
- R5: An accepted special mode set with address bit 5 high and bit 6 low loads `color_reg` from `dq` on the next clock edge and leaves `mask_reg` unchanged.
- R6: An accepted special mode set with address bits 5 and 6 both high loads `mask_reg` from `dq` on the first following edge and `color_reg` from `dq` on the second.
- R7: With only address bit 6 high, `mask_reg` loads on the next edge and `color_reg` does not change. With neither bit high, no register changes.
- R8: Mode set, special mode set and auto refresh while any bank is open decode as rejected, and load no register.
- R9: While a register load is pending, any command other than NOP or deselect decodes as rejected. It changes no bank state, and the data cycles still load as scheduled.
- R10: Activate on an open bank, and read, write or block write on an idle bank, decode as rejected. Burst stop is always accepted. Precharge with address bit 9 high closes every bank; with bit 9 low it closes only the bank on `ba`.
- R11: `op` has exactly one bit set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cmd_sel | input | 1 | Special-function select, picks graphics variants |
| ba | input | 1 | Bank select |
| addr | input | 11 | Address; bit 5 color select, bit 6 mask select, bit 9 all-bank precharge |
| dq | input | 32 | Data bus, source of register loads |
| op | output | 12 | Registered one-hot operation code |
| color_reg | output | 32 | Color register contents |
| mask_reg | output | 32 | Mask register contents |

## Verification
The hardest case to reach from the pins is a command issued inside the two-cycle mask-then-color window. That command must be refused, must leave the banks untouched, and must not disturb the data cycles. The stimulus gets there by issuing a double special mode set and then presenting an activate on the first data cycle and a write on the second. It then proves the activate had no effect with a read to the same bank, which must be refused. A sweep covers all sixteen strobe codes under both select levels, with the target bank first idle and then open. Expected codes come from a bench model of the decode rules and the bank state.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

    localparam int OP_N = 12;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ACT     = 4'd1,
        OP_ACT_WPB = 4'd2,
        OP_RD      = 4'd3,
        OP_WR      = 4'd4,
        OP_BLKWR   = 4'd5,
        OP_BST     = 4'd6,
        OP_PRE     = 4'd7,
        OP_REF     = 4'd8,
        OP_MRS     = 4'd9,
        OP_SMRS    = 4'd10,
        OP_REJ     = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        ST_READY      = 2'd0,
        ST_MASK_FIRST = 2'd1,
        ST_MASK_ONLY  = 2'd2,
        ST_COLOR_LAST = 2'd3
    } sreg_st_e;

endpackage

// File: rtl/gfx_pin_decode.sv
module gfx_pin_decode
    import gfx_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cmd_sel,
    output op_e  raw_op
);

    // Pure strobe decode; graphics variants chosen by cmd_sel.
    always_comb begin
        raw_op = OP_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  raw_op = OP_NOP;
                3'b011:  raw_op = cmd_sel ? OP_ACT_WPB : OP_ACT;
                3'b101:  raw_op = OP_RD;
                3'b100:  raw_op = cmd_sel ? OP_BLKWR : OP_WR;
                3'b110:  raw_op = OP_BST;
                3'b010:  raw_op = OP_PRE;
                3'b001:  raw_op = OP_REF;
                3'b000:  raw_op = cmd_sel ? OP_SMRS : OP_MRS;
                default: raw_op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/gfx_bank_track.sv
module gfx_bank_track
    import gfx_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  op_e                  acc_op,
    input  logic [BANK_W-1:0]    ba,
    input  logic                 pre_all,
    output logic [NUM_BANKS-1:0] bank_open
);

    // One open flag per bank, driven only by accepted commands.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (ba == BANK_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_open[g] <= 1'b0;
            end else if ((acc_op == OP_ACT || acc_op == OP_ACT_WPB) && hit) begin
                bank_open[g] <= 1'b1;
            end else if (acc_op == OP_PRE && (pre_all || hit)) begin
                bank_open[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gfx_sreg_fsm.sv
module gfx_sreg_fsm
    import gfx_cmd_pkg::*;
#(
    parameter int DQ_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smrs_go,
    input  logic            want_color,
    input  logic            want_mask,
    input  logic [DQ_W-1:0] dq,
    output sreg_st_e        st,
    output logic            loading,
    output logic [DQ_W-1:0] color_reg,
    output logic [DQ_W-1:0] mask_reg
);

    sreg_st_e st_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_READY;
        end else begin
            st <= st_nx;
        end
    end

    // Transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_READY: begin
                if (smrs_go) begin
                    if (want_mask && want_color) begin
                        st_nx = ST_MASK_FIRST;
                    end else if (want_mask) begin
                        st_nx = ST_MASK_ONLY;
                    end else if (want_color) begin
                        st_nx = ST_COLOR_LAST;
                    end
                end
            end
            ST_MASK_FIRST: st_nx = ST_COLOR_LAST;
            ST_MASK_ONLY:  st_nx = ST_READY;
            ST_COLOR_LAST: st_nx = ST_READY;
            default:       st_nx = ST_READY;
        endcase
    end

    assign loading = (st != ST_READY);

    // Register captures on the data cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            color_reg <= '0;
            mask_reg  <= '0;
        end else begin
            if (st == ST_MASK_FIRST || st == ST_MASK_ONLY) begin
                mask_reg <= dq;
            end
            if (st == ST_COLOR_LAST) begin
                color_reg <= dq;
            end
        end
    end

endmodule

// File: rtl/gfx_cmd_decoder.sv
module gfx_cmd_decoder
    import gfx_cmd_pkg::*;
#(
    parameter int DQ_W      = 32,
    parameter int ADDR_W    = 11,
    parameter int NUM_BANKS = 2,
    parameter int COLOR_BIT = 5,
    parameter int MASK_BIT  = 6,
    parameter int AP_BIT    = 9,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cmd_sel,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    output logic [OP_N-1:0]   op,
    output logic [DQ_W-1:0]   color_reg,
    output logic [DQ_W-1:0]   mask_reg
);

    op_e                  raw_op;
    op_e                  acc_op;
    sreg_st_e             st;
    logic                 loading;
    logic [NUM_BANKS-1:0] bank_open;
    logic                 any_open;
    logic                 tgt_open;
    logic                 addr_unused;

    assign addr_unused = ^addr;

    gfx_pin_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cmd_sel (cmd_sel),
        .raw_op  (raw_op)
    );

    assign any_open = |bank_open;
    assign tgt_open = bank_open[ba];

    // Acceptance gate: load window, then bank-state rules
    always_comb begin
        acc_op = raw_op;
        if (loading) begin
            acc_op = (raw_op == OP_NOP) ? OP_NOP : OP_REJ;
        end else begin
            unique case (raw_op)
                OP_ACT, OP_ACT_WPB:        if (tgt_open)  acc_op = OP_REJ;
                OP_RD, OP_WR, OP_BLKWR:    if (!tgt_open) acc_op = OP_REJ;
                OP_REF, OP_MRS, OP_SMRS:   if (any_open)  acc_op = OP_REJ;
                default:                   acc_op = raw_op;
            endcase
        end
    end

    gfx_bank_track #(
        .NUM_BANKS (NUM_BANKS)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_op    (acc_op),
        .ba        (ba),
        .pre_all   (addr[AP_BIT]),
        .bank_open (bank_open)
    );

    gfx_sreg_fsm #(
        .DQ_W (DQ_W)
    ) u_sreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .smrs_go    (acc_op == OP_SMRS),
        .want_color (addr[COLOR_BIT]),
        .want_mask  (addr[MASK_BIT]),
        .dq         (dq),
        .st         (st),
        .loading    (loading),
        .color_reg  (color_reg),
        .mask_reg   (mask_reg)
    );

    // Registered one-hot operation output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op <= OP_N'(1);
        end else begin
            op <= OP_N'(1) << acc_op;
        end
    end

endmodule

// File: rtl/gfx_cmd_decoder_chk.sv
module gfx_cmd_decoder_chk
    import gfx_cmd_pkg::*;
#(
    parameter int DQ_W      = 32,
    parameter int NUM_BANKS = 2,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 cmd_sel,
    input logic [BANK_W-1:0]    ba,
    input logic [OP_N-1:0]      op,
    input logic [DQ_W-1:0]      color_reg,
    input logic [DQ_W-1:0]      mask_reg,
    input sreg_st_e             st,
    input logic [NUM_BANKS-1:0] bank_open
);

    AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op) == 1); // R11

    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_READY && !cs_n && !(ras_n && cas_n && we_n)) |=> op[OP_REJ]); // R9

    AST_IDLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && !cs_n && !ras_n && !cas_n && (|bank_open)) |=> op[OP_REJ]); // R8

    AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_COLOR_LAST) |=> $stable(color_reg)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_MASK_FIRST && st != ST_MASK_ONLY) |=> $stable(mask_reg)); // R7

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MASK_FIRST) |=> (st == ST_COLOR_LAST)); // R6

    AST_WPB_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && !cs_n && !ras_n && cas_n && we_n && cmd_sel && !bank_open[ba])
        |=> op[OP_ACT_WPB]); // R3

endmodule

bind gfx_cmd_decoder gfx_cmd_decoder_chk #(
    .DQ_W      (DQ_W),
    .NUM_BANKS (NUM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .cmd_sel   (cmd_sel),
    .ba        (ba),
    .op        (op),
    .color_reg (color_reg),
    .mask_reg  (mask_reg),
    .st        (st),
    .bank_open (bank_open)
);

// File: tb/tb_gfx_cmd_decoder.sv
`timescale 1ns/1ps
module tb_gfx_cmd_decoder;

    localparam int X_NOP = 0, X_ACT = 1, X_WPB = 2, X_RD = 3, X_WR = 4, X_BLK = 5;
    localparam int X_BST = 6, X_PRE = 7, X_REF = 8, X_MRS = 9, X_SMRS = 10, X_REJ = 11;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101;
    localparam logic [3:0] C_WR = 4'b0100, C_BST = 4'b0110, C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001, C_MRS = 4'b0000;

    localparam int A_COL = 32, A_MSK = 64, A_ALL = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cmd_sel = 1'b0;
    logic [0:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [31:0] dq = '0;
    logic [11:0] op;
    logic [31:0] color_reg, mask_reg;

    int nvec = 0;
    int nfail = 0;
    bit bopen [2];
    int pend = 0;

    gfx_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cmd_sel(cmd_sel), .ba(ba), .addr(addr), .dq(dq),
        .op(op), .color_reg(color_reg), .mask_reg(mask_reg)
    );

    always #10 clk = ~clk;

    function automatic int model(input logic [3:0] pins, input logic s,
                                 input bit tgt, input bit any, input bit ld);
        int raw;
        if (pins[3]) raw = X_NOP;
        else begin
            case (pins[2:0])
                3'b111:  raw = X_NOP;
                3'b011:  raw = s ? X_WPB : X_ACT;
                3'b101:  raw = X_RD;
                3'b100:  raw = s ? X_BLK : X_WR;
                3'b110:  raw = X_BST;
                3'b010:  raw = X_PRE;
                3'b001:  raw = X_REF;
                default: raw = s ? X_SMRS : X_MRS;
            endcase
        end
        if (ld) return (raw == X_NOP) ? X_NOP : X_REJ;
        if ((raw == X_ACT || raw == X_WPB) && tgt) return X_REJ;
        if ((raw == X_RD || raw == X_WR || raw == X_BLK) && !tgt) return X_REJ;
        if ((raw == X_REF || raw == X_MRS || raw == X_SMRS) && any) return X_REJ;
        return raw;
    endfunction

    task automatic chk_op(input logic [11:0] act, input logic [11:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: op got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sampled at the rising edge, checked at the next falling edge.
    task automatic cmd(input logic [3:0] pins, input logic s, input int b, input int ad,
                       input logic [31:0] d, input string tag);
        int e;
        e = model(pins, s, bopen[b], bopen[0] | bopen[1], pend > 0);
        {cs_n, ras_n, cas_n, we_n} = pins;
        cmd_sel = s;
        ba = b[0:0];
        addr = ad[10:0];
        dq = d;
        @(negedge clk);
        chk_op(op, 12'(1) << e, tag);
        if (pend > 0) pend--;
        else if (e == X_SMRS) pend = ((ad >> 5) & 1) + ((ad >> 6) & 1);
        if (e == X_ACT || e == X_WPB) bopen[b] = 1'b1;
        if (e == X_PRE) begin
            if (((ad >> 9) & 1) != 0) begin
                bopen[0] = 1'b0;
                bopen[1] = 1'b0;
            end else bopen[b] = 1'b0;
        end
    endtask

    initial begin
        #4000000;
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] cexp, mexp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (and R11 single hot bit)
        chk_op(op, 12'h001, "R1 R11 reset op");
        chk32(color_reg, 32'h0, "R1 reset color");
        chk32(mask_reg, 32'h0, "R1 reset mask");

        // Sweep: all strobe codes, both select levels, target bank idle or open
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int p = 0; p < 16; p++) begin
                    string tag;
                    cmd(C_PRE, 1'b0, 0, A_ALL, 32'h0, "R10 precharge all");
                    if (o == 1) cmd(C_ACT, 1'b0, 0, 0, 32'h0, "R2 activate");
                    tag = (s == 0) ? "R2 sweep" : ((p == 0) ? "R4 sweep" : "R3 sweep");
                    cmd(4'(p), 1'(s), 0, 0, 32'h0, tag);
                end
            end
        end

        // R5: color-only load
        cmd(C_PRE, 1'b0, 0, A_ALL, 32'h0, "R10 precharge all");
        cmd(C_MRS, 1'b1, 0, A_COL, 32'h0, "R4 special mode set");
        cmd(C_NOP, 1'b0, 0, 0, 32'hC0C0_1234, "R5 color data cycle");
        chk32(color_reg, 32'hC0C0_1234, "R5 color loaded");
        chk32(mask_reg, 32'h0, "R5 mask untouched");

        // R6: mask first, color second
        cmd(C_MRS, 1'b1, 0, A_COL | A_MSK, 32'h0, "R6 special mode set both");
        cmd(C_NOP, 1'b0, 0, 0, 32'hAAAA_5555, "R6 mask cycle");
        chk32(mask_reg, 32'hAAAA_5555, "R6 mask after first cycle");
        chk32(color_reg, 32'hC0C0_1234, "R6 color held after first cycle");
        cmd(C_NOP, 1'b0, 0, 0, 32'h1357_9BDF, "R6 color cycle");
        chk32(color_reg, 32'h1357_9BDF, "R6 color after second cycle");
        chk32(mask_reg, 32'hAAAA_5555, "R6 mask held after second cycle");

        // R7: mask only, then neither
        cmd(C_MRS, 1'b1, 0, A_MSK, 32'h0, "R7 special mode set mask");
        cmd(C_NOP, 1'b0, 0, 0, 32'h0F0F_F0F0, "R7 mask cycle");
        cmd(C_NOP, 1'b0, 0, 0, 32'hDEAD_BEEF, "R7 idle after mask");
        chk32(mask_reg, 32'h0F0F_F0F0, "R7 mask loaded");
        chk32(color_reg, 32'h1357_9BDF, "R7 color untouched");
        cmd(C_MRS, 1'b1, 0, 0, 32'h0, "R7 special mode set none");
        cmd(C_NOP, 1'b0, 0, 0, 32'hFFFF_FFFF, "R7 no data cycle");
        chk32(mask_reg, 32'h0F0F_F0F0, "R7 mask unchanged");
        chk32(color_reg, 32'h1357_9BDF, "R7 color unchanged");

        // R9: commands inside the load window
        cmd(C_MRS, 1'b1, 0, A_COL | A_MSK, 32'h0, "R9 special mode set both");
        cmd(C_ACT, 1'b0, 0, 0, 32'h2468_ACE0, "R9 activate during mask cycle");
        cmd(C_WR, 1'b1, 0, 0, 32'h8642_0ECA, "R9 write during color cycle");
        chk32(mask_reg, 32'h2468_ACE0, "R9 mask still loads");
        chk32(color_reg, 32'h8642_0ECA, "R9 color still loads");
        cmd(C_RD, 1'b0, 0, 0, 32'h0, "R9 bank stayed idle");

        // R8: refused while a bank is open
        mexp = mask_reg;
        cexp = color_reg;
        cmd(C_ACT, 1'b0, 1, 0, 32'h0, "R8 open bank 1");
        cmd(C_MRS, 1'b1, 0, A_COL | A_MSK, 32'h0, "R8 special mode set refused");
        cmd(C_NOP, 1'b0, 0, 0, 32'h5A5A_5A5A, "R8 no load follows");
        cmd(C_NOP, 1'b0, 0, 0, 32'hA5A5_A5A5, "R8 no load follows");
        chk32(color_reg, cexp, "R8 color unchanged");
        chk32(mask_reg, mexp, "R8 mask unchanged");
        cmd(C_MRS, 1'b0, 0, 0, 32'h0, "R8 mode set refused");
        cmd(C_REF, 1'b0, 0, 0, 32'h0, "R8 refresh refused");

        // R10: bank bookkeeping
        cmd(C_ACT, 1'b1, 0, 0, 32'h0, "R10 open bank 0 with write-per-bit");
        cmd(C_ACT, 1'b0, 1, 0, 32'h0, "R10 activate open bank refused");
        cmd(C_PRE, 1'b0, 0, 0, 32'h0, "R10 precharge bank 0");
        cmd(C_RD, 1'b0, 0, 0, 32'h0, "R10 read closed bank 0");
        cmd(C_RD, 1'b0, 1, 0, 32'h0, "R10 read open bank 1");
        cmd(C_WR, 1'b1, 1, 0, 32'h0, "R3 block write open bank 1");
        cmd(C_BST, 1'b0, 0, 0, 32'h0, "R10 burst stop");
        cmd(C_PRE, 1'b0, 0, A_ALL, 32'h0, "R10 precharge all");
        cmd(C_WR, 1'b0, 1, 0, 32'h0, "R10 write after precharge all");
        cmd(C_REF, 1'b0, 0, 0, 32'h0, "R2 refresh all idle");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule